// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit wide first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be the same net or unrelated. Write and read pointers are held in binary and in Gray code. Each Gray pointer reaches the other domain through a two-stage synchroniser.

Each side computes its own status from its own pointer and the synchronised copy of the opposite pointer. The read side drives empty and almost-empty. The write side drives full, almost-full and half-full.

The two almost-flag thresholds are held in offset registers on the write side. Reset loads each with a default value. While the `load` input is high, each write-enabled cycle stores the low data bits into an offset register instead of the buffer. An output-enable input forces the read bus to zero while low.

Top module: `afifo_top`

## Requirements
- R1: While and after reset, with no writes since: empty=1, almost_empty=1, full=0, almost_full=0, half_full=0 and rd_data=0.
- R2: Words leave on the read side in the order they were accepted on the write side. This holds with the two clocks tied together and with unrelated clocks.
- R3: A write attempted while full=1 is dropped. The write pointer and the stored contents are unchanged, so the dropped word never appears on the read side.
- R4: A read attempted while empty=1 is dropped. The read pointer and rd_data are unchanged, and the next word written is the next word read.
- R5: full=1 exactly when DEPTH words are stored, as seen by the write side. empty=1 exactly when no word is stored, as seen by the read side.
- R6: almost_empty=1 when the stored count seen by the read side is less than or equal to the almost-empty offset. The default offset is 7.
- R7: almost_full=1 when the stored count seen by the write side is at least DEPTH minus the almost-full offset. The default offset is 7, so the default threshold is 9 words at DEPTH=16.
- R8: half_full=1 when the stored count seen by the write side is strictly greater than DEPTH/2.
- R9: Load behaviour:
  - While load=1, write-enabled cycles store wr_data[AW-1:0] into the offsets and push nothing into the buffer.
  - The first such cycle after load rises writes the almost-empty offset. The next writes the almost-full offset, and the writes then keep alternating.
  - Dropping load returns the sequence to the almost-empty offset.
- R10: With out_en=0, rd_data reads zero. Raising out_en again shows the word held in the output register.
- R11: Reset restores both offsets to their defaults, discarding any loaded values, and clears both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write request (buffer push, or offset write while load=1) |
| load | input | 1 | Routes write-enabled cycles to the offset registers |
| wr_data | input | 18 | Write data; low AW bits carry offsets during load |
| full | output | 1 | DEPTH words stored |
| almost_full | output | 1 | Count at or above DEPTH minus the almost-full offset |
| half_full | output | 1 | Count above DEPTH/2 |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Read request |
| out_en | input | 1 | Output enable; 0 forces rd_data to zero |
| rd_data | output | 18 | Registered read data |
| empty | output | 1 | No word stored |
| almost_empty | output | 1 | Count at or below the almost-empty offset |

## Verification
The bench fills the buffer to capacity and writes two more words. A design that let those writes through would overwrite the oldest entries, and the scoreboard would see wrong or missing words. It drains past empty and checks that rd_data holds and that a fresh word comes out next; a read pointer that slipped would return stale data. Every flag threshold is probed one word below and one word at its edge, where a wrong comparison (for example > where ≥ is meant) would flip the flag. The load sequence is run across two sessions with three writes in the first, which catches an order that never alternates or never restarts.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int DATA_W = 18;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } off_sel_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half_full;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_flags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/afifo_ram.sv
module afifo_ram #(
    parameter int AW = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  afifo_pkg::word_t  wdata,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output afifo_pkg::word_t  rdata
);
    localparam int N = 1 << AW;

    afifo_pkg::word_t store [N];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/afifo_offset_seq.sv
module afifo_offset_seq #(
    parameter int OW     = 4,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          wr_en,
    input  logic [OW-1:0] din,
    output logic [OW-1:0] ae_off,
    output logic [OW-1:0] af_off
);
    import afifo_pkg::*;

    off_sel_e sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= SEL_AE;
            ae_off <= OW'(AE_DEF);
            af_off <= OW'(AF_DEF);
        end else if (!load) begin
            sel <= SEL_AE;
        end else if (wr_en) begin
            if (sel == SEL_AE) begin
                ae_off <= din;
                sel    <= SEL_AF;
            end else begin
                af_off <= din;
                sel    <= SEL_AE;
            end
        end
    end

    // R9: offset writes alternate, almost-empty first
    assert_seq_alt_R9: assert property (@(posedge clk) disable iff (rst)
        (load && wr_en && sel == SEL_AE) |=> (sel == SEL_AF));

    assert_seq_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (!load) |=> (sel == SEL_AE));
endmodule

// File: rtl/afifo_top.sv
module afifo_top #(
    parameter int DEPTH  = 16,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7
) (
    input  logic        wr_clk,
    input  logic        wr_rst,
    input  logic        wr_en,
    input  logic        load,
    input  logic [17:0] wr_data,
    output logic        full,
    output logic        almost_full,
    output logic        half_full,
    input  logic        rd_clk,
    input  logic        rd_rst,
    input  logic        rd_en,
    input  logic        out_en,
    output logic [17:0] rd_data,
    output logic        empty,
    output logic        almost_empty
);
    import afifo_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int OW = AW;

    // ---------------- write domain ----------------
    logic [PW-1:0] wbin, wgray, rgray_ws, rbin_ws, wcount;
    logic [OW-1:0] ae_off, af_off;
    logic          push;
    wr_flags_t     wf;

    afifo_offset_seq #(.OW(OW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_seq (
        .clk   (wr_clk),
        .rst   (wr_rst),
        .load  (load),
        .wr_en (wr_en),
        .din   (wr_data[OW-1:0]),
        .ae_off(ae_off),
        .af_off(af_off)
    );

    afifo_sync #(.W(PW)) u_rsync (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_ws)
    );

    assign rbin_ws = PW'(gray_to_bin(32'(rgray_ws)));
    assign wcount  = wbin - rbin_ws;

    assign wf.full        = (wcount == PW'(DEPTH));
    assign wf.almost_full = (wcount >= (PW'(DEPTH) - PW'(af_off)));
    assign wf.half_full   = (wcount > PW'(DEPTH / 2));

    assign push = wr_en && !load && !wf.full;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin + 1'b1;
            wgray <= PW'(bin_to_gray(32'(wbin + 1'b1)));
        end
    end

    assign full        = wf.full;
    assign almost_full = wf.almost_full;
    assign half_full   = wf.half_full;

    // ---------------- read domain ----------------
    logic [PW-1:0] rbin, rgray, wgray_rs, wbin_rs, rcount;
    logic [OW-1:0] ae_off_rs;
    logic          pop;
    rd_flags_t     rf;
    word_t         rq;

    afifo_sync #(.W(PW)) u_wsync (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_rs)
    );

    // offsets change only during load, so a per-bit two-stage copy is enough
    afifo_sync #(.W(OW)) u_osync (
        .clk(rd_clk), .rst(rd_rst), .d(ae_off), .q(ae_off_rs)
    );

    assign wbin_rs = PW'(gray_to_bin(32'(wgray_rs)));
    assign rcount  = wbin_rs - rbin;

    assign rf.empty        = (rcount == '0);
    assign rf.almost_empty = (rcount <= PW'(ae_off_rs));

    assign pop = rd_en && !rf.empty;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin + 1'b1;
            rgray <= PW'(bin_to_gray(32'(rbin + 1'b1)));
        end
    end

    afifo_ram #(.AW(AW)) u_ram (
        .wclk (wr_clk),
        .we   (push),
        .waddr(wbin[AW-1:0]),
        .wdata(wr_data),
        .rclk (rd_clk),
        .rrst (rd_rst),
        .re   (pop),
        .raddr(rbin[AW-1:0]),
        .rdata(rq)
    );

    assign rd_data      = out_en ? rq : '0;
    assign empty        = rf.empty;
    assign almost_empty = rf.almost_empty;

    // ---------------- assertions ----------------
    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (full && wr_en && !load) |=> (wbin == $past(wbin)));

    assert_load_no_push_R9: assert property (@(posedge wr_clk) disable iff (wr_rst)
        load |=> $stable(wbin));

    assert_full_has_half_R8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        full |-> half_full);

    assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (empty && rd_en) |=> $stable(rbin));

    assert_rd_hold_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_en && !empty) |=> $stable(rq));
endmodule

// File: tb/test_afifo_top.sv
module test_afifo_top;

    localparam int DEPTH = 16;

    logic clk = 1'b0, clk2 = 1'b0, async_mode = 1'b0;
    logic rclk;
    logic rst = 1'b1;
    logic wr_en = 1'b0, load = 1'b0, rd_en = 1'b0, out_en = 1'b1;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic full, almost_full, half_full, empty, almost_empty;

    always #10 clk  = ~clk;
    always #14 clk2 = ~clk2;
    assign rclk = async_mode ? clk2 : clk;

    afifo_top #(.DEPTH(DEPTH)) i_afifo_top (
        .wr_clk(clk), .wr_rst(rst), .wr_en(wr_en), .load(load), .wr_data(wr_data),
        .full(full), .almost_full(almost_full), .half_full(half_full),
        .rd_clk(rclk), .rd_rst(rst), .rd_en(rd_en), .out_en(out_en),
        .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
    );

    int total = 0, bad = 0, rcv = 0;
    bit done = 0;
    logic [17:0] exp_q[$];
    logic        pend = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // scoreboard monitor: predicts a pop at the next rising edge, compares after it
    always @(negedge rclk) begin
        if (pend) begin
            logic [17:0] e;
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected word", {14'd0, rd_data}, 0);
            end else begin
                e = exp_q.pop_front();
                chk(rd_data == e, "R2 order", {14'd0, rd_data}, {14'd0, e});
            end
            rcv++;
        end
        pend = rd_en && !empty && out_en && !rst;
    end

    task automatic wr(input logic [17:0] d, output bit took);
        @(posedge clk); #3;
        wr_en = 1'b1; wr_data = d;
        took = !full && !load;
        if (took) exp_q.push_back(d);
        @(posedge clk); #3;
        wr_en = 1'b0;
    endtask

    task automatic wr1(input logic [17:0] d);
        bit t;
        wr(d, t);
    endtask

    task automatic rd1();
        @(posedge rclk); #3;
        rd_en = 1'b1;
        @(posedge rclk); #3;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
        repeat (2) @(negedge rclk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        repeat (4) @(negedge clk2);
        rst = 1'b0;
        settle();
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [17:0] last;
        do_reset();
        // R1 reset state
        chk(empty && almost_empty && !full && !almost_full && !half_full && rd_data == 0,
            "R1 reset flags", {26'd0, empty, almost_empty, full, almost_full, half_full, |rd_data}, 32'h30);

        // fill, probing thresholds (defaults 7/7, DEPTH 16)
        for (int i = 0; i < 16; i++) begin
            wr1(18'h100 + 18'(i));
            settle();
            if (i == 0) chk(!empty, "R5 empty clears", {31'd0, empty}, 0);
            if (i == 6) chk(almost_empty, "R6 ae at 7", {31'd0, almost_empty}, 1);
            if (i == 7) chk(!almost_empty, "R6 ae off at 8", {31'd0, almost_empty}, 0);
            if (i == 7) chk(!half_full && !almost_full, "R8 R7 at 8", {30'd0, half_full, almost_full}, 0);
            if (i == 8) chk(half_full, "R8 hf at 9", {31'd0, half_full}, 1);
            if (i == 8) chk(almost_full, "R7 af at 9", {31'd0, almost_full}, 1);
            if (i == 14) chk(!full, "R5 not full at 15", {31'd0, full}, 0);
        end
        chk(full, "R5 full at 16", {31'd0, full}, 1);
        // R3: writes while full are dropped
        wr1(18'h3DEAD); wr1(18'h3BEEF);
        settle();
        chk(full && exp_q.size() == 16, "R3 queue unchanged", exp_q.size(), 16);

        for (int i = 0; i < 16; i++) rd1();
        settle();
        chk(empty && rcv == 16, "R3 R5 drained", rcv, 16);
        last = rd_data;
        chk(last == 18'h10F, "R2 last word", {14'd0, last}, 32'h10F);

        // R4: reads while empty ignored
        rd1(); rd1();
        settle();
        chk(rd_data == last && empty, "R4 hold on empty read", {14'd0, rd_data}, {14'd0, last});
        wr1(18'h2AAAA);
        settle();
        rd1();
        settle();
        chk(rd_data == 18'h2AAAA && exp_q.size() == 0, "R4 next word", {14'd0, rd_data}, 32'h2AAAA);

        // R10 output enable
        out_en = 1'b0;
        #1;
        chk(rd_data == 0, "R10 disabled zero", {14'd0, rd_data}, 0);
        out_en = 1'b1;
        #1;
        chk(rd_data == 18'h2AAAA, "R10 re-enabled", {14'd0, rd_data}, 32'h2AAAA);

        // R9 offset load: 5->ae, 6->af, 2->ae; restart: 1->ae
        @(posedge clk); #3; load = 1'b1;
        wr1(18'd5); wr1(18'd6); wr1(18'd2);
        @(posedge clk); #3; load = 1'b0;
        @(posedge clk); #3; load = 1'b1;
        wr1(18'h3FFC1);
        @(posedge clk); #3; load = 1'b0;
        settle();
        chk(empty, "R9 load pushes nothing", {31'd0, empty}, 1);
        for (int i = 1; i <= 10; i++) begin
            wr1(18'h200 + 18'(i));
            settle();
            if (i == 1) chk(almost_empty, "R9 ae=1 at 1", {31'd0, almost_empty}, 1);
            if (i == 2) chk(!almost_empty, "R9 ae=1 at 2", {31'd0, almost_empty}, 0);
            if (i == 9) chk(!almost_full, "R9 af=6 at 9", {31'd0, almost_full}, 0);
            if (i == 10) chk(almost_full, "R9 af=6 at 10", {31'd0, almost_full}, 1);
        end

        // R11 reset restores defaults
        exp_q.delete();
        do_reset();
        chk(empty && !almost_full, "R11 pointers cleared", {30'd0, empty, almost_full}, 2);
        for (int i = 0; i < 9; i++) begin
            wr1(18'h300 + 18'(i));
            settle();
            if (i == 6) chk(almost_empty, "R11 ae default at 7", {31'd0, almost_empty}, 1);
            if (i == 7) chk(!almost_empty && !almost_full, "R11 defaults at 8", {30'd0, almost_empty, almost_full}, 0);
            if (i == 8) chk(almost_full, "R11 af default at 9", {31'd0, almost_full}, 1);
        end

        // R2 with unrelated clocks
        exp_q.delete();
        rst = 1'b1;
        async_mode = 1'b1;
        do_reset();
        rcv = 0;
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    bit t;
                    t = 0;
                    while (!t) wr(18'h1000 + 18'(i * 37), t);
                end
            end
            begin
                while (rcv < 40) rd1();
            end
        join
        settle();
        chk(rcv == 40 && exp_q.size() == 0 && empty, "R2 async stream", rcv, 40);
        finish_run();
    end
endmodule